// File: doc/BRIEF.md
# Command-Block Logical-Unit Rewriter

This block sits on the target side of a parallel SCSI bus, after the byte-level handshake. It watches each received byte, which comes tagged with the bus phase it arrived in. A message-out byte that is an IDENTIFY message supplies a logical unit number (LUN). The block assembles the command descriptor block (CDB) from the command-phase bytes. When the block is complete and a LUN was captured during the current selection, the LUN field in byte 1 of the CDB is replaced by the captured value. The CDB is then handed to the command decoder with a one-cycle strobe. A normal bus sequence places the accepted IDENTIFY byte just before the command phase.

A pulse on `sel_start` begins a new selection. It discards the captured LUN and any partial CDB. The command length comes in on `cmd_len`, so 6-, 10- and 12-byte blocks all use the same path. Separately, a bus reset marks a pending unit attention on every target ID. While any target is pending, the sense pair "reset occurred" (0x29/0x02) is presented. The consumer clears each target's flag with its own acknowledge bit.

The byte input is a valid/ready stream. A byte transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only in the single cycle in which `cmd_rdy` is high. A source that keeps `in_valid` asserted through that cycle has its byte taken on the following edge, exactly once. The CDB output has no back-pressure: the consumer must capture `cdb_o` while `cmd_rdy` is high.

Top module: `cdb_lun_patcher`

## Requirements
- R1: After synchronous active-high reset, `cmd_rdy` is 0, `ua_pend` is all zero, `ua_code` is 0 and `in_ready` is 1.
- R2: A byte is taken only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly in the cycle `cmd_rdy` is high, and a byte held through that cycle is taken once, on the next edge.
- R3: The phase tag `in_phase` is encoded as 2'b01 = message-out and 2'b10 = command. Bytes with any other tag are taken but change neither the captured LUN nor the CDB.
- R4: A message-out byte with bit 7 = 1 and bit 5 = 0 is an IDENTIFY. Its bits 2:0 become the captured LUN, which is then valid. A later IDENTIFY overwrites it, and any other message-out byte leaves it unchanged.
- R5: A `sel_start` pulse marks the LUN invalid, restarts the CDB byte count and zeroes `cdb_o`. It takes precedence over an IDENTIFY byte or a command byte taken in the same cycle.
- R6: Command bytes are stored in arrival order, byte k at `cdb_o[8k+7:8k]`. On the edge that takes byte number `cmd_len` (counting from 1), the block completes. `cmd_rdy` is then high for exactly the next cycle, and `cdb_o` holds the block from that cycle until the next command byte arrives.
- R7: If the LUN is valid at completion, `cdb_o` bits 15:13 (byte 1, bits 7:5) equal the captured LUN, and bits 12:8 keep the received value.
- R8: If the LUN is invalid at completion, byte 1 of `cdb_o` equals the received byte unchanged.
- R9: A `bus_rst` pulse sets all eight bits of `ua_pend` on the next edge.
- R10: A pulse on `ua_ack[t]` clears `ua_pend[t]` only. When `bus_rst` is high in the same cycle, it wins and the bit stays set.
- R11: `ua_code` reads 16'h2902 (sense code 0x29, qualifier 0x02) while any `ua_pend` bit is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received byte is present |
| in_ready | output | 1 | Block accepts the byte this cycle |
| in_data | input | 8 | Received bus byte |
| in_phase | input | 2 | Phase tag: 01 message-out, 10 command |
| sel_start | input | 1 | Pulse at the start of a selection |
| bus_rst | input | 1 | Pulse on a bus reset |
| cmd_len | input | 4 | Command block length in bytes |
| cdb_o | output | 96 | Assembled, patched command block, byte 0 in bits 7:0 |
| cmd_rdy | output | 1 | One-cycle strobe: `cdb_o` is complete |
| ua_ack | input | 8 | Per-target pulse to clear pending unit attention |
| ua_pend | output | 8 | Per-target pending unit attention |
| ua_code | output | 16 | Sense code and qualifier while any attention is pending |

## Verification
Every result here is one register away from its stimulus. `cmd_rdy`, the patched `cdb_o`, the captured LUN and `ua_pend` all change on the edge that takes the byte or strobe. `in_ready` and `ua_code` follow combinationally from those registers. The bench drives inputs on the falling edge and samples on the following falling edge, so each value is read in the cycle it is due. The one-cycle width of `cmd_rdy` is checked on the falling edge after that. The held-valid case checks that `in_ready` is low in the strobe cycle, and that the held byte shows up once, as byte 0 of the next block.

// File: rtl/lunp_pkg.sv
package lunp_pkg;
  typedef enum logic [1:0] {
    PH_NONE  = 2'b00,
    PH_MSGO  = 2'b01,
    PH_CMD   = 2'b10,
    PH_OTHER = 2'b11
  } phase_e;

  localparam logic [7:0] UA_ASC  = 8'h29;
  localparam logic [7:0] UA_ASCQ = 8'h02;

  function automatic logic is_identify(input logic [7:0] b);
    return b[7] & ~b[5];
  endfunction
endpackage

// File: rtl/lunp_capture.sv
module lunp_capture
  import lunp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_start,
  input  logic       msg_fire,
  input  logic [7:0] msg_byte,
  output logic       lun_vld,
  output logic [2:0] lun_val
);
  always_ff @(posedge clk) begin
    if (rst || sel_start) begin
      lun_vld <= 1'b0;
      lun_val <= '0;
    end else if (msg_fire && is_identify(msg_byte)) begin
      lun_vld <= 1'b1;
      lun_val <= msg_byte[2:0];
    end
  end
endmodule

// File: rtl/lunp_cdb_buf.sv
module lunp_cdb_buf #(
  parameter int MAX_CDB = 12,
  parameter int LENW    = $clog2(MAX_CDB + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_start,
  input  logic               cmd_fire,
  input  logic [7:0]         cmd_byte,
  input  logic [LENW-1:0]    cmd_len,
  input  logic               lun_vld,
  input  logic [2:0]         lun_val,
  output logic [8*MAX_CDB-1:0] cdb_flat,
  output logic               done
);
  logic [7:0]      mem [MAX_CDB];
  logic [LENW-1:0] cnt;
  logic            last;

  // final byte when the count reaches the requested length or the storage end
  assign last = ((cnt + LENW'(1)) == cmd_len) || (cnt == LENW'(MAX_CDB - 1));

  always_ff @(posedge clk) begin
    if (rst || sel_start) begin
      cnt  <= '0;
      done <= 1'b0;
      for (int i = 0; i < MAX_CDB; i++) mem[i] <= '0;
    end else begin
      done <= 1'b0;
      if (cmd_fire) begin
        for (int i = 0; i < MAX_CDB; i++)
          if (cnt == LENW'(i)) mem[i] <= cmd_byte;
        if (last) begin
          cnt  <= '0;
          done <= 1'b1;
          if (lun_vld) mem[1][7:5] <= lun_val;
        end else begin
          cnt <= cnt + LENW'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < MAX_CDB; g++) begin : g_flat
    assign cdb_flat[8*g +: 8] = mem[g];
  end
endmodule

// File: rtl/lunp_ua.sv
module lunp_ua #(
  parameter int N_TGT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst,
  input  logic [N_TGT-1:0] ua_ack,
  output logic [N_TGT-1:0] ua_pend
);
  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst)            ua_pend[t] <= 1'b0;
      else if (bus_rst)   ua_pend[t] <= 1'b1;
      else if (ua_ack[t]) ua_pend[t] <= 1'b0;
    end
  end
endmodule

// File: rtl/cdb_lun_patcher.sv
module cdb_lun_patcher
  import lunp_pkg::*;
#(
  parameter int MAX_CDB = 12,
  parameter int N_TGT   = 8,
  localparam int LENW   = $clog2(MAX_CDB + 1),
  localparam int CDBW   = 8 * MAX_CDB
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic [1:0]      in_phase,
  input  logic            sel_start,
  input  logic            bus_rst,
  input  logic [LENW-1:0] cmd_len,
  output logic [CDBW-1:0] cdb_o,
  output logic            cmd_rdy,
  input  logic [N_TGT-1:0] ua_ack,
  output logic [N_TGT-1:0] ua_pend,
  output logic [15:0]     ua_code
);
  logic fire, msg_fire, cmd_fire;
  logic lun_vld;
  logic [2:0] lun_val;

  assign in_ready = ~cmd_rdy;
  assign fire     = in_valid & in_ready;
  assign msg_fire = fire && (phase_e'(in_phase) == PH_MSGO);
  assign cmd_fire = fire && (phase_e'(in_phase) == PH_CMD);

  lunp_capture u_cap (
    .clk(clk), .rst(rst), .sel_start(sel_start),
    .msg_fire(msg_fire), .msg_byte(in_data),
    .lun_vld(lun_vld), .lun_val(lun_val)
  );

  lunp_cdb_buf #(.MAX_CDB(MAX_CDB), .LENW(LENW)) u_buf (
    .clk(clk), .rst(rst), .sel_start(sel_start),
    .cmd_fire(cmd_fire), .cmd_byte(in_data), .cmd_len(cmd_len),
    .lun_vld(lun_vld), .lun_val(lun_val),
    .cdb_flat(cdb_o), .done(cmd_rdy)
  );

  lunp_ua #(.N_TGT(N_TGT)) u_ua (
    .clk(clk), .rst(rst), .bus_rst(bus_rst),
    .ua_ack(ua_ack), .ua_pend(ua_pend)
  );

  assign ua_code = (|ua_pend) ? {UA_ASC, UA_ASCQ} : 16'h0000;
endmodule

// File: rtl/lunp_chk.sv
module lunp_chk #(
  parameter int N_TGT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             cmd_rdy,
  input logic             sel_start,
  input logic             lun_vld,
  input logic             bus_rst,
  input logic [N_TGT-1:0] ua_ack,
  input logic [N_TGT-1:0] ua_pend
);
  a_r2_no_take_on_strobe: assert property (@(posedge clk) disable iff (rst)
    cmd_rdy |-> !in_ready);

  a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cmd_rdy |=> !cmd_rdy);

  a_r5_select_drops_lun: assert property (@(posedge clk) disable iff (rst)
    sel_start |=> !lun_vld);

  a_r9_reset_arms_all: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (ua_pend == {N_TGT{1'b1}}));

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_rst && ua_ack == '0) |=> $stable(ua_pend));
endmodule

bind cdb_lun_patcher lunp_chk #(.N_TGT(N_TGT)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .cmd_rdy(cmd_rdy),
  .sel_start(sel_start), .lun_vld(lun_vld), .bus_rst(bus_rst),
  .ua_ack(ua_ack), .ua_pend(ua_pend)
);

// File: tb/cdb_lun_patcher_tb_top.sv
module cdb_lun_patcher_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic [1:0]  in_phase = '0;
  logic        sel_start = 1'b0;
  logic        bus_rst = 1'b0;
  logic [3:0]  cmd_len = 4'd6;
  logic [95:0] cdb_o;
  logic        cmd_rdy;
  logic [7:0]  ua_ack = '0;
  logic [7:0]  ua_pend;
  logic [15:0] ua_code;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cdb_lun_patcher dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_phase(in_phase), .sel_start(sel_start),
    .bus_rst(bus_rst), .cmd_len(cmd_len), .cdb_o(cdb_o), .cmd_rdy(cmd_rdy),
    .ua_ack(ua_ack), .ua_pend(ua_pend), .ua_code(ua_code)
  );

  // {has_msg, msg_byte, length, byte1_in, byte1_expected}
  localparam logic [28:0] VEC [6] = '{
    {1'b1, 8'h83, 4'd6,  8'h1F, 8'h7F},
    {1'b0, 8'h00, 4'd10, 8'hE5, 8'hE5},
    {1'b1, 8'hC5, 4'd12, 8'h20, 8'hA0},
    {1'b1, 8'hA2, 4'd6,  8'hFF, 8'hFF},
    {1'b1, 8'h07, 4'd10, 8'h40, 8'h40},
    {1'b1, 8'h80, 4'd6,  8'hE3, 8'h03}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] ph, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_phase = ph; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sel();
    @(negedge clk); sel_start = 1'b1;
    @(negedge clk); sel_start = 1'b0;
  endtask

  // sends len command bytes: byte k = {tag,k}, byte 1 = b1
  task automatic send_cdb(input logic [3:0] tag, input int len, input logic [7:0] b1);
    cmd_len = 4'(len);
    for (int k = 0; k < len; k++)
      put(2'b10, (k == 1) ? b1 : {tag, 4'(k)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cmd_rdy", 32'(cmd_rdy), 0);
    chk("R1 ua_pend", 32'(ua_pend), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    chk("R11 ua_code idle", 32'(ua_code), 0);

    // vector table: R4 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      sel();
      if (VEC[v][28]) put(2'b01, VEC[v][27:20]);
      send_cdb(4'(v + 1), int'(VEC[v][19:16]), VEC[v][15:8]);
      chk($sformatf("R6 vec%0d strobe", v), 32'(cmd_rdy), 1);
      chk($sformatf("R2 vec%0d ready low", v), 32'(in_ready), 0);
      chk($sformatf("R7/R8 vec%0d byte1", v), 32'(cdb_o[15:8]), 32'(VEC[v][7:0]));
      for (int k = 0; k < int'(VEC[v][19:16]); k++)
        if (k != 1)
          chk($sformatf("R6 vec%0d byte%0d", v, k), 32'(cdb_o[8*k +: 8]),
              32'({4'(v + 1), 4'(k)}));
      @(negedge clk);
      chk($sformatf("R6 vec%0d pulse width", v), 32'(cmd_rdy), 0);
    end

    // R3: other-phase bytes have no effect
    sel();
    put(2'b11, 8'h84);
    put(2'b10, 8'h70);
    put(2'b00, 8'h55);
    put(2'b10, 8'h3C);
    for (int k = 2; k < 6; k++) put(2'b10, 8'h70 + 8'(k));
    chk("R3 strobe after 6 cmd bytes", 32'(cmd_rdy), 1);
    chk("R3 byte1 unpatched", 32'(cdb_o[15:8]), 32'h3C);
    chk("R3 byte2", 32'(cdb_o[23:16]), 32'h72);

    // R4: later IDENTIFY overwrites
    sel();
    put(2'b01, 8'h82);
    put(2'b01, 8'h86);
    send_cdb(4'hA, 6, 8'h01);
    chk("R4 last identify wins", 32'(cdb_o[15:8]), 32'hC1);

    // R5: select after identify invalidates
    sel();
    put(2'b01, 8'h85);
    sel();
    send_cdb(4'hB, 6, 8'h11);
    chk("R5 lun invalidated", 32'(cdb_o[15:8]), 32'h11);

    // R5: select same cycle as identify wins
    sel();
    @(negedge clk);
    sel_start = 1'b1; in_valid = 1'b1; in_phase = 2'b01; in_data = 8'h87;
    @(negedge clk);
    sel_start = 1'b0; in_valid = 1'b0;
    send_cdb(4'hC, 6, 8'h08);
    chk("R5 select beats identify", 32'(cdb_o[15:8]), 32'h08);

    // R5: count restart and cdb cleared
    sel();
    cmd_len = 4'd6;
    for (int k = 0; k < 3; k++) put(2'b10, 8'hEE);
    sel();
    chk("R5 cdb cleared", 32'(cdb_o[31:0]), 0);
    for (int k = 0; k < 5; k++) put(2'b10, 8'h20 + 8'(k));
    chk("R5 no early strobe", 32'(cmd_rdy), 0);
    put(2'b10, 8'h25);
    chk("R5 strobe after restart", 32'(cmd_rdy), 1);
    chk("R5 byte0 after restart", 32'(cdb_o[7:0]), 32'h20);

    // R2: byte held through strobe cycle taken once
    sel();
    for (int k = 0; k < 5; k++) put(2'b10, 8'h40 + 8'(k));
    @(negedge clk);
    in_valid = 1'b1; in_phase = 2'b10; in_data = 8'h45;
    @(negedge clk);
    chk("R2 strobe", 32'(cmd_rdy), 1);
    chk("R2 ready low in strobe", 32'(in_ready), 0);
    in_data = 8'hB0;
    @(negedge clk);
    chk("R2 ready back", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 1; k < 6; k++) put(2'b10, 8'hB0 + 8'(k));
    chk("R2 held byte strobe", 32'(cmd_rdy), 1);
    chk("R2 held byte is byte0", 32'(cdb_o[7:0]), 32'hB0);
    chk("R2 held byte once", 32'(cdb_o[15:8]), 32'hB1);

    // R9 R10 R11: unit attention
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    chk("R9 all set", 32'(ua_pend), 32'hFF);
    chk("R11 code", 32'(ua_code), 32'h2902);
    ua_ack = 8'h08;
    @(negedge clk); ua_ack = '0;
    chk("R10 single clear", 32'(ua_pend), 32'hF7);
    ua_ack = 8'h01; bus_rst = 1'b1;
    @(negedge clk); ua_ack = '0; bus_rst = 1'b0;
    chk("R10 reset wins", 32'(ua_pend), 32'hFF);
    ua_ack = 8'hFF;
    @(negedge clk); ua_ack = '0;
    chk("R10 all cleared", 32'(ua_pend), 0);
    chk("R11 code cleared", 32'(ua_code), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule